// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside an SRAM-style memory port and watches each completed access. A host that can only issue ordinary reads and writes uses it to request nonvolatile operations. It reads a fixed chain of six addresses in order. The first five addresses are common to both commands, and the sixth selects the command: save the array to nonvolatile storage, or restore the array from it. The detector holds no data. Once a chain is complete, it emits a single-cycle request pulse to a separate nonvolatile controller, which drives a busy input back while it works.

Any access that does not fit the chain cancels it. This covers a write cycle, a read of an unexpected address, or a read at the final step that selects neither command. A read of the chain's first address always starts a fresh attempt. The prefix addresses, the two final addresses and the address width are parameters. A generate option picks either registered request outputs (the default) or combinational ones.

Top module: `rdseq_cmd_detector`

## Requirements
- R1: After a synchronous active-high reset, both request outputs are low and the detector is idle, so a complete six-read chain is needed before any request.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, each presented as one cycle with acc_valid high and acc_write low, raise store_req. With the default registered outputs, store_req is high in the cycle after the clock edge that samples the sixth read.
- R3: The same five-read prefix followed by a read of 0x0F0E raises recall_req with the same timing as R2.
- R4: A read of an address not expected at the current step cancels the chain. Completing the remaining steps afterwards issues no request.
- R5: A write (acc_write high) at any step cancels the chain, even when its address equals the expected one. This includes a write to the final address.
- R6: A read of 0x0000 at any step where 0x0000 is not the expected address counts at once as step one of a new chain.
- R7: While busy is high, all accesses are ignored and the detector returns to idle. A chain interrupted by busy does not complete afterwards.
- R8: Each request pulse is exactly one clock wide, and store_req and recall_req are never high together.
- R9: At the sixth step, a read of any address other than the two final addresses cancels the chain with no request.
- R10: Cycles with acc_valid low between accesses do not disturb the progress of a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe marking a completed access |
| acc_write | input | 1 | High when the access is a write |
| acc_addr | input | 13 | Address of the access |
| busy | input | 1 | Nonvolatile controller is working; accesses are ignored |
| store_req | output | 1 | One-cycle request to save the array |
| recall_req | output | 1 | One-cycle request to restore the array |

## Verification
The clean chains ending in 0x0F0F and in 0x0F0E separate the two commands and fix the exact pulse cycle. A wrong final address shows that the last step decodes both targets and nothing else. Chains broken by a stray read, by a matching-address write at a middle step and at the final step, and by busy show that each cancel path empties the progress, because the rest of the chain is then replayed and must stay silent. A stray read of 0x0000 mid-chain followed by the remainder, and a chain padded with idle cycles, tell a proper restart and a strobe-qualified counter apart from a design that merely resets or counts every clock.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
   typedef enum logic [1:0] {
      RSD_CMD_NONE   = 2'd0,
      RSD_CMD_STORE  = 2'd1,
      RSD_CMD_RECALL = 2'd2
   } rsd_cmd_e;

   function automatic int unsigned rsd_step_width(input int unsigned prefix_len);
      return $clog2(prefix_len + 1);
   endfunction
endpackage

// File: rtl/rsd_step_match.sv
module rsd_step_match #(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned PREFIX_LEN = 5,
   parameter int unsigned STEP_W     = 3,
   parameter logic [PREFIX_LEN*ADDR_W-1:0] PREFIX = '0,
   parameter logic [ADDR_W-1:0] STORE_ADDR  = '0,
   parameter logic [ADDR_W-1:0] RECALL_ADDR = '0
) (
   input  logic [STEP_W-1:0] step,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_step,
   output logic              hit_first,
   output logic              hit_store,
   output logic              hit_recall
);
   logic [PREFIX_LEN-1:0] eq;

   for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
      assign eq[i] = (addr == PREFIX[i*ADDR_W +: ADDR_W]);
   end

   always_comb begin
      hit_step = 1'b0;
      for (int i = 0; i < PREFIX_LEN; i++) begin
         if (step == STEP_W'(i)) hit_step = eq[i];
      end
   end

   assign hit_first  = eq[0];
   assign hit_store  = (addr == STORE_ADDR);
   assign hit_recall = (addr == RECALL_ADDR);
endmodule

// File: rtl/rsd_step_ctr.sv
module rsd_step_ctr
   import rsd_pkg::*;
#(
   parameter int unsigned PREFIX_LEN = 5,
   parameter int unsigned STEP_W     = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              busy,
   input  logic              hit_step,
   input  logic              hit_first,
   input  logic              hit_store,
   input  logic              hit_recall,
   output logic [STEP_W-1:0] step_q,
   output rsd_cmd_e          cmd
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);
   localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

   logic [STEP_W-1:0] step_nx;
   logic              rd;

   assign rd = acc_valid && !acc_write && !busy;

   always_comb begin
      step_nx = step_q;
      cmd     = RSD_CMD_NONE;
      if (busy) begin
         step_nx = '0;
      end else if (acc_valid) begin
         if (acc_write) begin
            step_nx = '0;
         end else if (step_q == LAST) begin
            if (hit_store)       cmd = RSD_CMD_STORE;
            else if (hit_recall) cmd = RSD_CMD_RECALL;
            if (hit_store || hit_recall) step_nx = '0;
            else                         step_nx = hit_first ? ONE : '0;
         end else if (hit_step) begin
            step_nx = step_q + ONE;
         end else begin
            step_nx = hit_first ? ONE : '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) step_q <= '0;
      else     step_q <= step_nx;
   end

   // R5: a write always cancels progress
   p_write_abort_r5: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_write && !busy) |=> (step_q == '0));

   // R7: busy forces idle
   p_busy_idle_r7: assert property (@(posedge clk) disable iff (rst)
      busy |=> (step_q == '0));

   // R6: first address from idle starts step one
   p_first_start_r6: assert property (@(posedge clk) disable iff (rst)
      (rd && step_q == '0 && hit_first) |=> (step_q == ONE));

   // R4: progress never runs past the final step
   p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
      step_q <= LAST);

   // R10: no strobe, no change
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (!acc_valid && !busy) |=> $stable(step_q));
endmodule

// File: rtl/rsd_cmd_out.sv
module rsd_cmd_out
   import rsd_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic     clk,
   input  logic     rst,
   input  rsd_cmd_e cmd,
   output logic     store_req,
   output logic     recall_req
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
         end else begin
            store_req  <= (cmd == RSD_CMD_STORE);
            recall_req <= (cmd == RSD_CMD_RECALL);
         end
      end
   end else begin : g_comb
      assign store_req  = (cmd == RSD_CMD_STORE);
      assign recall_req = (cmd == RSD_CMD_RECALL);
   end
endmodule

// File: rtl/rdseq_cmd_detector.sv
module rdseq_cmd_detector
   import rsd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned PREFIX_LEN = 5,
   parameter logic [PREFIX_LEN*ADDR_W-1:0] PREFIX =
      {13'h10F0, 13'h1FFF, 13'h0AAA, 13'h1555, 13'h0000},
   parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
   parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              busy,
   output logic              store_req,
   output logic              recall_req
);
   localparam int unsigned STEP_W = rsd_step_width(PREFIX_LEN);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);

   if (ADDR_W < 1) begin : g_bad_aw
      $error("ADDR_W must be at least 1");
   end
   if (PREFIX_LEN < 1) begin : g_bad_len
      $error("PREFIX_LEN must be at least 1");
   end
   if (STORE_ADDR == RECALL_ADDR) begin : g_bad_final
      $error("final addresses must differ");
   end

   logic [STEP_W-1:0] step_q;
   logic              hit_step, hit_first, hit_store, hit_recall;
   rsd_cmd_e          cmd;

   rsd_step_match #(
      .ADDR_W(ADDR_W), .PREFIX_LEN(PREFIX_LEN), .STEP_W(STEP_W),
      .PREFIX(PREFIX), .STORE_ADDR(STORE_ADDR), .RECALL_ADDR(RECALL_ADDR)
   ) u_match (
      .step(step_q), .addr(acc_addr),
      .hit_step(hit_step), .hit_first(hit_first),
      .hit_store(hit_store), .hit_recall(hit_recall)
   );

   rsd_step_ctr #(.PREFIX_LEN(PREFIX_LEN), .STEP_W(STEP_W)) u_ctr (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
      .busy(busy), .hit_step(hit_step), .hit_first(hit_first),
      .hit_store(hit_store), .hit_recall(hit_recall),
      .step_q(step_q), .cmd(cmd)
   );

   rsd_cmd_out #(.REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst(rst), .cmd(cmd),
      .store_req(store_req), .recall_req(recall_req)
   );

   // R8: the two requests are exclusive
   p_onehot_req_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({store_req, recall_req}));

   // R8: each pulse is a single cycle
   p_store_single_r8: assert property (@(posedge clk) disable iff (rst)
      store_req |=> !store_req);
   p_recall_single_r8: assert property (@(posedge clk) disable iff (rst)
      recall_req |=> !recall_req);

   if (REG_OUT) begin : g_reg_chk
      // R2: a store pulse follows a read at the final step
      p_store_after_last_r2: assert property (@(posedge clk) disable iff (rst)
         $rose(store_req) |-> $past(step_q == LAST && acc_valid && !acc_write));
      // R3: a recall pulse follows a read at the final step
      p_recall_after_last_r3: assert property (@(posedge clk) disable iff (rst)
         $rose(recall_req) |-> $past(step_q == LAST && acc_valid && !acc_write));
   end
endmodule

// File: tb/rdseq_cmd_detector_tb.sv
module rdseq_cmd_detector_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [12:0] acc_addr = '0;
   logic        busy = 1'b0;
   logic        store_req, recall_req;

   int checks = 0;
   int fails  = 0;
   int st_cnt = 0;
   int rc_cnt = 0;
   bit done   = 1'b0;

   localparam logic [12:0] PFX [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
   localparam logic [12:0] A_ST = 13'h0F0F;
   localparam logic [12:0] A_RC = 13'h0F0E;

   rdseq_cmd_detector u_dut (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .busy(busy), .store_req(store_req), .recall_req(recall_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (!rst && store_req)  st_cnt++;
      if (!rst && recall_req) rc_cnt++;
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge with valid dropped
   task automatic acc(input logic wr, input logic [12:0] a);
      acc_valid = 1'b1; acc_write = wr; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic prefix_from(input int first);
      for (int i = first; i < 5; i++) acc(1'b0, PFX[i]);
   endtask

   task automatic t_reset;
      rst = 1'b1; idle(3);
      check("R1 store low in reset", store_req, 0);
      check("R1 recall low in reset", recall_req, 0);
      rst = 1'b0; idle(1);
      acc(1'b0, A_ST); idle(2);
      check("R1 lone final read after reset", st_cnt, 0);
   endtask

   task automatic t_store;
      int s0 = st_cnt;
      prefix_from(0);
      acc(1'b0, A_ST);
      check("R2 store pulse cycle", store_req, 1);
      check("R8 no recall with store", recall_req, 0);
      @(negedge clk);
      check("R8 store one cycle wide", store_req, 0);
      check("R2 store count", st_cnt - s0, 1);
   endtask

   task automatic t_recall;
      int r0 = rc_cnt;
      int s0 = st_cnt;
      prefix_from(0);
      acc(1'b0, A_RC);
      check("R3 recall pulse cycle", recall_req, 1);
      check("R8 no store with recall", store_req, 0);
      @(negedge clk);
      check("R8 recall one cycle wide", recall_req, 0);
      check("R3 recall count", rc_cnt - r0, 1);
      check("R3 no store on recall", st_cnt - s0, 0);
   endtask

   task automatic t_wrong_read;
      int s0 = st_cnt;
      prefix_from(0);
      acc(1'b0, 13'h0001);
      acc(1'b0, A_ST); idle(2);
      check("R4 stray read at step six", st_cnt - s0, 0);
      acc(1'b0, PFX[0]); acc(1'b0, PFX[1]); acc(1'b0, 13'h1234);
      prefix_from(3); acc(1'b0, A_ST); idle(2);
      check("R4 stray read mid chain", st_cnt - s0, 0);
   endtask

   task automatic t_write;
      int s0 = st_cnt;
      acc(1'b0, PFX[0]); acc(1'b1, PFX[1]);
      prefix_from(2); acc(1'b0, A_ST); idle(2);
      check("R5 matching write mid chain", st_cnt - s0, 0);
      prefix_from(0); acc(1'b1, A_ST); idle(2);
      check("R5 write at final step", st_cnt - s0, 0);
      acc(1'b1, PFX[0]); prefix_from(1); acc(1'b0, A_ST); idle(2);
      check("R5 write of first address", st_cnt - s0, 0);
   endtask

   task automatic t_restart;
      int s0 = st_cnt;
      acc(1'b0, PFX[0]); acc(1'b0, PFX[1]); acc(1'b0, PFX[2]);
      acc(1'b0, PFX[0]);
      prefix_from(1); acc(1'b0, A_ST); idle(1);
      check("R6 restart on first address", st_cnt - s0, 1);
      prefix_from(0); acc(1'b0, PFX[0]);
      prefix_from(1); acc(1'b0, A_ST); idle(1);
      check("R6 restart at final step", st_cnt - s0, 2);
   endtask

   task automatic t_busy;
      int s0 = st_cnt;
      busy = 1'b1;
      prefix_from(0); acc(1'b0, A_ST); idle(2);
      check("R7 full chain during busy", st_cnt - s0, 0);
      busy = 1'b0;
      prefix_from(0);
      busy = 1'b1; idle(2); busy = 1'b0;
      acc(1'b0, A_ST); idle(2);
      check("R7 chain cut by busy", st_cnt - s0, 0);
      prefix_from(0); acc(1'b0, A_ST); idle(1);
      check("R7 works after busy", st_cnt - s0, 1);
   endtask

   task automatic t_bad_final;
      int s0 = st_cnt;
      int r0 = rc_cnt;
      prefix_from(0); acc(1'b0, 13'h0F0D); acc(1'b0, A_RC); idle(2);
      check("R9 wrong final store count", st_cnt - s0, 0);
      check("R9 wrong final recall count", rc_cnt - r0, 0);
   endtask

   task automatic t_gaps;
      int r0 = rc_cnt;
      for (int i = 0; i < 5; i++) begin
         acc(1'b0, PFX[i]); idle(i + 1);
      end
      acc(1'b0, A_RC);
      check("R10 recall with gaps", recall_req, 1);
      idle(1);
      check("R10 recall count with gaps", rc_cnt - r0, 1);
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset;
      t_store;
      t_recall;
      t_wrong_read;
      t_write;
      t_restart;
      t_busy;
      t_bad_final;
      t_gaps;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule